// File: doc/BRIEF.md
# Flash Command Launch Controller

This block fronts an on-chip nonvolatile array with a small byte-wide register interface. Software selects a parameter slot through an index register, writes a command code and parameter bytes, and then launches the command by writing a one to the command-complete bit of the status register. At the launch edge the block validates the request. A launch with an uninitialized clock divider, an unsupported command code or a non-zero parameter index is refused: the access-error flag is raised and nothing runs. A valid launch starts the command against an internal array model that can infer block RAM.

The only command the block runs is a whole-array blank check (code 0x01). The check reads every word once, one word per clock, and compares it with the erased value (all ones). Each array word also carries two test marks, one for a correctable read error and one for a non-correctable one. The check reports through two status bits. The upper bit means that some error was seen. The lower bit means that a non-correctable error was seen or that the blank check failed. The host can also read the array directly. A read made while a command runs returns zero and raises both fault-detect flags.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, the status register (address 1) reads 0x80, the fault register (address 2) reads 0x00 and `cmd_done` is 1.
- R2: Writing status with bit 7 = 1 while done = 1 and the access error clear, with the launch accepted, clears done at that write edge. Done returns to 1 exactly DEPTH+1 clock edges later.
- R3: If the divider register (address 0) has never been written, a launch sets the access error (status bit 5) and done stays 1. The first divider write marks the divider initialized until reset, and the divider value reads back.
- R4: A launch with any command code (address 4) other than 0x01 sets the access error and runs nothing.
- R5: A launch of code 0x01 with the index register (address 3, bits 2:0) not equal to 0 sets the access error and runs nothing.
- R6: A launch write made while the access error is set, or while a command is running, is ignored. Done, status and completion timing are unchanged.
- R7: The access error (status bit 5) and the two fault flags (fault bits 1 and 0) are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R8: A blank check over an array that is all ones reports status bits 1:0 = 00. Any word that is not all ones, at any address, reports 11.
- R9: A correctable mark on any word reports 10. A non-correctable mark reports 11. Both status bits are cleared at every accepted launch.
- R10: A host array read while idle returns the stored word one clock after the request. A host read during a command returns zero and sets both fault flags.
- R11: A write to address 5 stores a parameter byte in the slot selected by the index register, and a read of address 5 returns the byte in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 3 | Register read address |
| reg_rd_data | output | 8 | Register read data, valid one clock after the strobe |
| cmd_done | output | 1 | Command-complete flag |
| arr_rd_en | input | 1 | Host array read strobe |
| arr_rd_addr | input | ADDR_W | Host array read address |
| arr_rd_data | output | DATA_W | Host array read data, valid one clock after the strobe |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | ADDR_W | Array load address |
| ld_data | input | DATA_W | Array load data |
| ld_ce_mark | input | 1 | Correctable-error mark for the loaded word |
| ld_ue_mark | input | 1 | Non-correctable-error mark for the loaded word |

## Verification
Register reads and host array reads are due one clock edge after the strobe. The bench samples them one time unit after that edge. A refused launch shows in the access error at the launch edge, and the bench checks that done is still 1 in the cycle after it. For an accepted launch, the bench counts edges from the launch edge until done is seen high and compares the count with DEPTH+1. It does the same with a stray launch written in the middle of a run, so a late or early completion shows up as a count mismatch rather than as a timeout.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;
  localparam logic [7:0] CMD_BLANK_ALL = 8'h01;

  localparam logic [REG_AW-1:0] RA_DIV   = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT  = 3'd1;
  localparam logic [REG_AW-1:0] RA_FAULT = 3'd2;
  localparam logic [REG_AW-1:0] RA_IDX   = 3'd3;
  localparam logic [REG_AW-1:0] RA_CMD   = 3'd4;
  localparam logic [REG_AW-1:0] RA_PARAM = 3'd5;

  localparam int ST_DONE = 7;
  localparam int ST_ACC  = 5;

  typedef struct packed {
    logic any_err;
    logic hard_err;
  } vstat_t;
endpackage

// File: rtl/flc_mem.sv
module flc_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ce,
  input  logic              wr_ue,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ce,
  output logic              rd_ue
);
  localparam int DEPTH = 2 ** ADDR_W;
  localparam int WORD_W = DATA_W + 2;

  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= {wr_ue, wr_ce, wr_data};
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= store[rd_addr];
  end

  assign rd_data = q[DATA_W-1:0];
  assign rd_ce   = q[DATA_W];
  assign rd_ue   = q[DATA_W+1];
endmodule

// File: rtl/flc_verify.sv
module flc_verify
  import flc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_ce,
  input  logic              rd_ue,
  output logic              busy,
  output logic              fin,
  output vstat_t            fin_stat
);
  localparam int DEPTH = 2 ** ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic issued_all, pend;
  logic acc_any, acc_hard;
  logic word_blank, word_any, word_hard;

  assign word_blank = &rd_data;
  assign word_any   = rd_ce | rd_ue | ~word_blank;
  assign word_hard  = rd_ue | ~word_blank;

  assign rd_en = busy & ~issued_all;
  assign fin   = busy & issued_all & pend;
  assign fin_stat.any_err  = acc_any  | (pend & word_any);
  assign fin_stat.hard_err = acc_hard | (pend & word_hard);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      issued_all <= 1'b0;
      pend       <= 1'b0;
      acc_any    <= 1'b0;
      acc_hard   <= 1'b0;
      rd_addr    <= '0;
    end else if (start) begin
      busy       <= 1'b1;
      issued_all <= 1'b0;
      pend       <= 1'b0;
      acc_any    <= 1'b0;
      acc_hard   <= 1'b0;
      rd_addr    <= '0;
    end else if (busy) begin
      pend <= rd_en;
      if (rd_en) begin
        rd_addr <= rd_addr + 1'b1;
        if (rd_addr == LAST) issued_all <= 1'b1;
      end
      if (pend) begin
        acc_any  <= acc_any | word_any;
        acc_hard <= acc_hard | word_hard;
      end
      if (fin) busy <= 1'b0;
    end
  end

  // independent run-length counter for the completion window
  logic [ADDR_W:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst || start) run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
  end

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  assert_fin_window_R2: assert property (@(posedge clk) disable iff (rst)
    fin |-> run_cnt == (ADDR_W+1)'(DEPTH));
  assert_fin_idle_R2: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy);
endmodule

// File: rtl/flc_regs.sv
module flc_regs
  import flc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [REG_DW-1:0] rd_data,
  input  logic              eng_fin,
  input  vstat_t            eng_stat,
  input  logic              fault_set,
  output logic              launch_go,
  output logic              done_o
);
  localparam int NPARAM = 2 ** IDX_W;

  logic [REG_DW-1:0] div_q, cmd_q;
  logic [REG_DW-1:0] param_q [NPARAM];
  logic [IDX_W-1:0]  idx_q;
  logic              div_ok_q, done_q, acc_q, flt_a_q, flt_b_q;
  vstat_t            vstat_q;

  logic wr_stat, launch_try, launch_ok, launch_valid, launch_bad;

  assign wr_stat      = wr_en && (wr_addr == RA_STAT);
  assign launch_try   = wr_stat && wr_data[ST_DONE];
  assign launch_ok    = launch_try && done_q && !acc_q;
  assign launch_valid = div_ok_q && (cmd_q == CMD_BLANK_ALL) && (idx_q == '0);
  assign launch_go    = launch_ok && launch_valid;
  assign launch_bad   = launch_ok && !launch_valid;
  assign done_o       = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      div_ok_q <= 1'b0;
      cmd_q    <= '0;
      idx_q    <= '0;
    end else if (wr_en) begin
      if (wr_addr == RA_DIV) begin
        div_q    <= wr_data;
        div_ok_q <= 1'b1;
      end
      if (wr_addr == RA_CMD) cmd_q <= wr_data;
      if (wr_addr == RA_IDX) idx_q <= wr_data[IDX_W-1:0];
    end
  end

  generate
    for (genvar g = 0; g < NPARAM; g++) begin : g_param
      always_ff @(posedge clk) begin
        if (rst) param_q[g] <= '0;
        else if (wr_en && wr_addr == RA_PARAM && idx_q == IDX_W'(g))
          param_q[g] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b1;
      acc_q   <= 1'b0;
      vstat_q <= '0;
    end else begin
      if (launch_go) begin
        done_q  <= 1'b0;
        vstat_q <= '0;
      end else if (eng_fin) begin
        done_q  <= 1'b1;
        vstat_q <= eng_stat;
      end
      if (launch_bad) acc_q <= 1'b1;
      else if (wr_stat && wr_data[ST_ACC]) acc_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_a_q <= 1'b0;
      flt_b_q <= 1'b0;
    end else if (fault_set) begin
      flt_a_q <= 1'b1;
      flt_b_q <= 1'b1;
    end else if (wr_en && wr_addr == RA_FAULT) begin
      if (wr_data[1]) flt_a_q <= 1'b0;
      if (wr_data[0]) flt_b_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      case (rd_addr)
        RA_DIV:   rd_data <= div_q;
        RA_STAT:  rd_data <= {done_q, 1'b0, acc_q, 3'b000, vstat_q.any_err, vstat_q.hard_err};
        RA_FAULT: rd_data <= {6'b0, flt_a_q, flt_b_q};
        RA_IDX:   rd_data <= REG_DW'(idx_q);
        RA_CMD:   rd_data <= cmd_q;
        RA_PARAM: rd_data <= param_q[idx_q];
        default:  rd_data <= '0;
      endcase
    end
  end

  assert_launch_clears_done_R2: assert property (@(posedge clk) disable iff (rst)
    launch_go |=> !done_q);
  assert_blocked_launch_R6: assert property (@(posedge clk) disable iff (rst)
    (launch_try && done_q && acc_q) |=> (done_q && acc_q));
  assert_bad_code_refused_R4: assert property (@(posedge clk) disable iff (rst)
    (launch_ok && cmd_q != CMD_BLANK_ALL) |=> (acc_q && done_q));
  assert_divider_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    div_ok_q |=> div_ok_q);
  assert_fault_pair_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flt_a_q) |-> flt_b_q);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_addr,
  input  logic [7:0]        reg_wr_data,
  input  logic              reg_rd_en,
  input  logic [2:0]        reg_rd_addr,
  output logic [7:0]        reg_rd_data,
  output logic              cmd_done,
  input  logic              arr_rd_en,
  input  logic [ADDR_W-1:0] arr_rd_addr,
  output logic [DATA_W-1:0] arr_rd_data,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_ce_mark,
  input  logic              ld_ue_mark
);
  logic              launch_go, eng_busy, eng_fin, eng_rd_en;
  logic [ADDR_W-1:0] eng_addr;
  vstat_t            eng_stat;
  logic              mem_rd_en, mem_ce, mem_ue, host_ok_q;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [DATA_W-1:0] mem_q;

  // the engine owns the single read port while it runs
  assign mem_rd_en   = eng_busy ? eng_rd_en : arr_rd_en;
  assign mem_rd_addr = eng_busy ? eng_addr  : arr_rd_addr;

  always_ff @(posedge clk) begin
    if (rst) host_ok_q <= 1'b0;
    else     host_ok_q <= arr_rd_en & ~eng_busy;
  end
  assign arr_rd_data = host_ok_q ? mem_q : '0;

  flc_regs #(.IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_en(reg_rd_en), .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .eng_fin(eng_fin), .eng_stat(eng_stat),
    .fault_set(arr_rd_en & eng_busy),
    .launch_go(launch_go), .done_o(cmd_done)
  );

  flc_verify #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) verify_i (
    .clk(clk), .rst(rst), .start(launch_go),
    .rd_en(eng_rd_en), .rd_addr(eng_addr),
    .rd_data(mem_q), .rd_ce(mem_ce), .rd_ue(mem_ue),
    .busy(eng_busy), .fin(eng_fin), .fin_stat(eng_stat)
  );

  flc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
    .clk(clk),
    .wr_en(ld_en), .wr_addr(ld_addr), .wr_data(ld_data),
    .wr_ce(ld_ce_mark), .wr_ue(ld_ue_mark),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
    .rd_data(mem_q), .rd_ce(mem_ce), .rd_ue(mem_ue)
  );

  assert_host_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    (arr_rd_en && eng_busy) |=> (arr_rd_data == '0));
endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int N  = 2 ** AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 0, reg_rd_en = 0, arr_rd_en = 0, ld_en = 0, ld_ce = 0, ld_ue = 0;
  logic [2:0] reg_wr_addr = 0, reg_rd_addr = 0;
  logic [7:0] reg_wr_data = 0, reg_rd_data;
  logic cmd_done;
  logic [AW-1:0] arr_rd_addr = 0, ld_addr = 0;
  logic [DW-1:0] arr_rd_data, ld_data = 0;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.DATA_W(DW), .ADDR_W(AW), .IDX_W(3)) dut_i (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .cmd_done(cmd_done),
    .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .ld_ce_mark(ld_ce), .ld_ue_mark(ld_ue)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    @(posedge clk); #1;
    reg_wr_en = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    reg_rd_en = 1; reg_rd_addr = a;
    @(posedge clk); #1;
    d = reg_rd_data; reg_rd_en = 0;
  endtask

  task automatic load(input int a, input logic [DW-1:0] d, input logic ce, input logic ue);
    ld_en = 1; ld_addr = AW'(a); ld_data = d; ld_ce = ce; ld_ue = ue;
    @(posedge clk); #1;
    ld_en = 0; ld_ce = 0; ld_ue = 0;
  endtask

  task automatic wait_done(inout int cnt);
    while (!cmd_done && cnt < 1000) begin
      @(posedge clk); #1;
      cnt++;
    end
  endtask

  // accepted launch: completion timing and final status
  task automatic run_check(input string tag, input logic [7:0] exp_stat);
    int cnt = 0;
    logic [7:0] s;
    reg_wr(3'd1, 8'h80);
    wait_done(cnt);
    chk({tag, " R2 completion edges"}, cnt, N + 1);
    reg_rd(3'd1, s);
    chk(tag, s, exp_stat);
  endtask

  // refused launch: done must stay high, access error set, then cleared
  task automatic refused_check(input string tag);
    logic [7:0] s;
    reg_wr(3'd1, 8'h80);
    chk({tag, " done held"}, cmd_done, 1'b1);
    reg_rd(3'd1, s);
    chk({tag, " acc err"}, s, 8'hA0);
    reg_wr(3'd1, 8'h20);
  endtask

  initial begin
    #(200000 * 4);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int cnt;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    for (int a = 0; a < N; a++) load(a, '1, 0, 0);

    // R1 reset values
    reg_rd(3'd1, s); chk("R1 status", s, 8'h80);
    reg_rd(3'd2, s); chk("R1 fault", s, 8'h00);
    chk("R1 cmd_done", cmd_done, 1'b1);

    // R3 divider guard
    reg_wr(3'd4, 8'h01);
    reg_wr(3'd3, 8'h00);
    reg_wr(3'd1, 8'h80);
    chk("R3 done held", cmd_done, 1'b1);
    reg_rd(3'd1, s); chk("R3 acc err", s, 8'hA0);

    // R6 launch while access error set is ignored
    reg_wr(3'd0, 8'h13);
    reg_wr(3'd1, 8'h80);
    chk("R6 done held", cmd_done, 1'b1);
    @(posedge clk); #1;
    chk("R6 still idle", cmd_done, 1'b1);
    reg_rd(3'd1, s); chk("R6 status", s, 8'hA0);

    // R7 write-zero keeps, write-one clears
    reg_wr(3'd1, 8'h00);
    reg_rd(3'd1, s); chk("R7 acc kept", s, 8'hA0);
    reg_wr(3'd1, 8'h20);
    reg_rd(3'd1, s); chk("R7 acc cleared", s, 8'h80);
    reg_rd(3'd0, s); chk("R3 divider readback", s, 8'h13);

    // R4 sweep of every command code
    for (int c = 0; c < 256; c++) begin
      reg_wr(3'd4, 8'(c));
      if (c == 1) run_check("R4 R8 valid code blank", 8'h80);
      else refused_check("R4 bad code");
    end
    reg_wr(3'd4, 8'h01);

    // R5 index sweep, R11 parameter slots
    for (int i = 1; i < 8; i++) begin
      reg_wr(3'd3, 8'(i));
      reg_wr(3'd5, 8'(8'h30 + i));
      refused_check("R5 bad index");
    end
    for (int i = 1; i < 8; i++) begin
      reg_wr(3'd3, 8'(i));
      reg_rd(3'd5, s); chk("R11 param slot", s, 8'(8'h30 + i));
    end
    reg_wr(3'd3, 8'h00);

    // R8 one non-blank word at each address
    for (int k = 0; k < N; k++) begin
      load(k, ~(DW'(1) << (k % DW)), 0, 0);
      run_check("R8 blank fail", 8'h83);
      load(k, '1, 0, 0);
    end

    // R9 error marks at each address, and clearing at the next launch
    for (int k = 0; k < N; k++) begin
      load(k, '1, 1, 0);
      run_check("R9 correctable", 8'h82);
      load(k, '1, 0, 1);
      run_check("R9 non-correctable", 8'h83);
      load(k, '1, 0, 0);
    end
    run_check("R9 status cleared", 8'h80);

    // R6 second launch while busy is ignored
    cnt = 0;
    reg_wr(3'd1, 8'h80);
    reg_wr(3'd1, 8'h80);
    cnt = 1;
    chk("R6 busy done low", cmd_done, 1'b0);
    wait_done(cnt);
    chk("R6 busy timing", cnt, N + 1);
    reg_rd(3'd1, s); chk("R6 busy status", s, 8'h80);

    // R10 host reads idle and busy
    load(5, 8'h5A, 0, 0);
    arr_rd_en = 1; arr_rd_addr = 4'd5;
    @(posedge clk); #1; arr_rd_en = 0;
    chk("R10 idle read", arr_rd_data, 8'h5A);
    reg_rd(3'd2, s); chk("R10 no fault idle", s, 8'h00);
    load(5, '1, 0, 0);
    reg_wr(3'd1, 8'h80);
    arr_rd_en = 1; arr_rd_addr = 4'd3;
    @(posedge clk); #1; arr_rd_en = 0;
    chk("R10 busy read zero", arr_rd_data, 8'h00);
    cnt = 1;
    wait_done(cnt);
    reg_rd(3'd2, s); chk("R10 faults set", s, 8'h03);
    reg_wr(3'd2, 8'h02);
    reg_rd(3'd2, s); chk("R7 fault a cleared", s, 8'h01);
    reg_wr(3'd2, 8'h01);
    reg_rd(3'd2, s); chk("R7 fault b cleared", s, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule